// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter Slice

A binary up-counter slice whose width is a parameter (four bits by default). Every change of the stored count happens on a rising clock edge. An active-low clear and an active-low parallel load act on that edge, and both win over counting. Counting needs two enables to be high at once: a "count enable" and a "carry enable". The carry enable also gates a combinational terminal-count output. This output is high while the count sits at its all-ones value.

Wider counters are built by chaining slices. The terminal-count output of one stage drives the carry enable of the next stage. The count enable of every stage is tied to one shared enable. No extra gating is needed between stages.

A shorter modulus comes from decoding a chosen maximum count into an active-low signal and feeding it to the clear input. The count then returns to zero on the edge after that maximum is reached.

Top module: `sync_count_slice`

## Requirements
- R1: The count `cnt_q` changes only on a rising edge of `clk`. Input changes between edges leave it unchanged until the next edge.
- R2: When `sclr_n` is 0 at an edge, `cnt_q` becomes 0. This holds for any level of `pload_n`, `cnt_en` and `carry_en`.
- R3: When `sclr_n` is 1 and `pload_n` is 0 at an edge, `cnt_q` takes `din`. This holds for any level of `cnt_en` and `carry_en`.
- R4: When `sclr_n`, `pload_n`, `cnt_en` and `carry_en` are all 1 at an edge, `cnt_q` increases by one.
- R5: Counting from the all-ones value (15 at the default width) gives 0 on the next edge.
- R6: When neither clear nor load is active and either enable is 0 at an edge, `cnt_q` keeps its value.
- R7: `tc_out` equals `carry_en` AND (`cnt_q` is all ones), combinationally. It does not depend on `cnt_en`.
- R8: Two slices are chained: the low stage's `tc_out` drives the high stage's `carry_en`, and both share `cnt_en`. The pair counts 0 through 255 and wraps to 0.
- R9: A decode of count 9 fed into `sclr_n` gives a repeating sequence 0..9.
- R10: The sequence clear, then load 12, then six count edges gives 0, 12, 13, 14, 15, 0, 1, 2. With the enables low afterwards, the count holds at 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| sclr_n | input | 1 | Synchronous clear, active low |
| pload_n | input | 1 | Synchronous parallel load, active low |
| din | input | WIDTH | Parallel preset value |
| cnt_en | input | 1 | Count enable, does not affect the carry output |
| carry_en | input | 1 | Count enable that also gates the carry output |
| cnt_q | output | WIDTH | Stored count |
| tc_out | output | 1 | Terminal count: carry_en AND count all ones |

## Verification
The block has no reset. The assertions therefore take for granted that a clear is applied before the count is relied on. They stay disabled until two edges have passed. The stimulus applies a clear on the first edges of every phase. Inputs are driven only in the middle of the high clock phase. Each edge thus sees settled control levels, and the checks on the carry output between edges are valid. Random phases mix clear, load, both enables and data with fixed bias, so every mode is reached many times.

// File: rtl/scnt_pkg.sv
package scnt_pkg;

   typedef enum logic [1:0] {
      MODE_HOLD  = 2'd0,
      MODE_COUNT = 2'd1,
      MODE_LOAD  = 2'd2,
      MODE_CLEAR = 2'd3
   } scnt_mode_e;

endpackage

// File: rtl/scnt_mode_sel.sv
// Priority decode: clear > load > count > hold (R2, R3, R4, R6)
module scnt_mode_sel
   import scnt_pkg::*;
(
   input  logic       clr_n,
   input  logic       ld_n,
   input  logic       en_a,
   input  logic       en_b,
   output scnt_mode_e mode
);

   always_comb begin
      if (!clr_n)            mode = MODE_CLEAR;
      else if (!ld_n)        mode = MODE_LOAD;
      else if (en_a && en_b) mode = MODE_COUNT;
      else                   mode = MODE_HOLD;
   end

endmodule

// File: rtl/scnt_incr.sv
// Incrementer with per-bit toggle terms; LOOKAHEAD selects wide AND terms
// versus a rippled AND chain.
module scnt_incr #(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] val,
   output logic [WIDTH-1:0] val_plus,
   output logic             all_ones
);

   logic [WIDTH-1:0] tog;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("scnt_incr: WIDTH must be at least 1");
      end

      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i == 0) begin : g_lsb
            assign tog[i] = 1'b1;
         end else if (LOOKAHEAD) begin : g_la
            assign tog[i] = &val[i-1:0];
         end else begin : g_rip
            assign tog[i] = tog[i-1] & val[i-1];
         end
         assign val_plus[i] = val[i] ^ tog[i];
      end
   endgenerate

   assign all_ones = tog[WIDTH-1] & val[WIDTH-1];

endmodule

// File: rtl/sync_count_slice.sv
module sync_count_slice
   import scnt_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic             clk,
   input  logic             sclr_n,
   input  logic             pload_n,
   input  logic [WIDTH-1:0] din,
   input  logic             cnt_en,
   input  logic             carry_en,
   output logic [WIDTH-1:0] cnt_q,
   output logic             tc_out
);

   localparam logic [WIDTH-1:0] ZERO = '0;

   generate
      if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
         $error("sync_count_slice: WIDTH out of range 1..64");
      end
   endgenerate

   scnt_mode_e       mode;
   logic [WIDTH-1:0] cnt_plus;
   logic             full;
   logic [WIDTH-1:0] cnt_d;

   scnt_mode_sel u_mode (
      .clr_n (sclr_n),
      .ld_n  (pload_n),
      .en_a  (cnt_en),
      .en_b  (carry_en),
      .mode  (mode)
   );

   scnt_incr #(
      .WIDTH     (WIDTH),
      .LOOKAHEAD (LOOKAHEAD)
   ) u_incr (
      .val      (cnt_q),
      .val_plus (cnt_plus),
      .all_ones (full)
   );

   always_comb begin
      unique case (mode)
         MODE_CLEAR: cnt_d = ZERO;
         MODE_LOAD:  cnt_d = din;
         MODE_COUNT: cnt_d = cnt_plus;
         default:    cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk) begin
      cnt_q <= cnt_d;
   end

   // terminal count gated only by carry_en (R7)
   assign tc_out = carry_en & full;

   // ---------------- assertions ----------------
   logic [1:0] armed = 2'b00;
   always_ff @(posedge clk) begin
      armed <= {armed[0], 1'b1};
   end

   a_r2_clear_wins: assert property (@(posedge clk) disable iff (!armed[1])
      !sclr_n |=> (cnt_q == ZERO));

   a_r3_load_takes_din: assert property (@(posedge clk) disable iff (!armed[1])
      (sclr_n && !pload_n) |=> (cnt_q == $past(din)));

   a_r4_count_step: assert property (@(posedge clk) disable iff (!armed[1])
      (sclr_n && pload_n && cnt_en && carry_en) |=> (cnt_q == WIDTH'($past(cnt_q) + 1'b1)));

   a_r6_hold: assert property (@(posedge clk) disable iff (!armed[1])
      (sclr_n && pload_n && !(cnt_en && carry_en)) |=> $stable(cnt_q));

   a_r7_tc_needs_carry_en: assert property (@(posedge clk) disable iff (!armed[1])
      tc_out |-> (carry_en && (&cnt_q)));

   a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!armed[1])
      (sclr_n && pload_n && cnt_en && tc_out) |=> (cnt_q == ZERO));

endmodule

// File: tb/sync_count_slice_test.sv
module sync_count_slice_test;

   localparam int W = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] model_next(input logic [W-1:0] q, input logic c_n,
                                               input logic l_n, input logic [W-1:0] d,
                                               input logic ea, input logic eb);
      if (!c_n)          return '0;
      else if (!l_n)     return d;
      else if (ea && eb) return q + 1'b1;
      else               return q;
   endfunction

   function automatic logic model_tc(input logic [W-1:0] q, input logic eb);
      return eb && (q == {W{1'b1}});
   endfunction

   // ---------- main slice ----------
   logic         sclr_n = 1'b1, pload_n = 1'b1, cnt_en = 1'b0, carry_en = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] cnt_q;
   logic         tc_out;

   sync_count_slice #(.WIDTH(W)) uut (
      .clk(clk), .sclr_n(sclr_n), .pload_n(pload_n), .din(din),
      .cnt_en(cnt_en), .carry_en(carry_en), .cnt_q(cnt_q), .tc_out(tc_out)
   );

   // ---------- two-slice chain (R8), ripple-style incrementer ----------
   logic         ch_clr_n = 1'b1, ch_en = 1'b0;
   logic [W-1:0] lo_q, hi_q;
   logic         lo_tc, hi_tc;

   sync_count_slice #(.WIDTH(W), .LOOKAHEAD(1'b0)) u_lo (
      .clk(clk), .sclr_n(ch_clr_n), .pload_n(1'b1), .din('0),
      .cnt_en(ch_en), .carry_en(1'b1), .cnt_q(lo_q), .tc_out(lo_tc)
   );
   sync_count_slice #(.WIDTH(W), .LOOKAHEAD(1'b0)) u_hi (
      .clk(clk), .sclr_n(ch_clr_n), .pload_n(1'b1), .din('0),
      .cnt_en(ch_en), .carry_en(lo_tc), .cnt_q(hi_q), .tc_out(hi_tc)
   );

   // ---------- shortened modulus (R9) ----------
   logic         md_init_n = 1'b1, md_en = 1'b0;
   logic [W-1:0] md_q;
   logic         md_tc;
   logic         md_clr_n;
   assign md_clr_n = md_init_n & (md_q != 4'd9);

   sync_count_slice #(.WIDTH(W)) u_mod (
      .clk(clk), .sclr_n(md_clr_n), .pload_n(1'b1), .din('0),
      .cnt_en(md_en), .carry_en(md_en), .cnt_q(md_q), .tc_out(md_tc)
   );

   // drive in mid high phase, check after
   task automatic edge_wait();
      @(posedge clk); #2;
   endtask

   task automatic drive(input logic c_n, input logic l_n, input logic [W-1:0] d,
                        input logic ea, input logic eb);
      sclr_n = c_n; pload_n = l_n; din = d; cnt_en = ea; carry_en = eb;
   endtask

   logic [W-1:0] exp_q;

   task automatic step_check(input string req);
      logic [W-1:0] nq;
      nq = model_next(exp_q, sclr_n, pload_n, din, cnt_en, carry_en);
      edge_wait();
      exp_q = nq;
      chk(cnt_q == exp_q, req, cnt_q, exp_q);
      chk(tc_out == model_tc(exp_q, carry_en), "R7", tc_out, model_tc(exp_q, carry_en));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd5150));
      #2;
      // reset state via clear
      drive(1'b0, 1'b1, 4'd0, 1'b1, 1'b1);
      edge_wait(); edge_wait();
      exp_q = '0;
      chk(cnt_q == 4'd0, "R2 clear to zero", cnt_q, 0);

      // R10 reference sequence
      drive(1'b1, 1'b0, 4'd12, 1'b0, 1'b0);
      step_check("R10 preset 12");
      drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
      for (int k = 0; k < 6; k++) step_check("R10 count");
      chk(cnt_q == 4'd2, "R10 end value", cnt_q, 2);
      drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b0);
      step_check("R10 inhibit"); step_check("R10 inhibit");

      // R2 clear over load and count
      drive(1'b1, 1'b0, 4'd7, 1'b0, 1'b0);
      step_check("R3 load 7");
      drive(1'b0, 1'b0, 4'd5, 1'b1, 1'b1);
      step_check("R2 clear beats load");
      chk(cnt_q == 4'd0, "R2 priority", cnt_q, 0);

      // R3 load beats count
      drive(1'b1, 1'b0, 4'd9, 1'b1, 1'b1);
      step_check("R3 load beats count");

      // R6 hold with each enable low alone
      drive(1'b1, 1'b1, 4'd0, 1'b0, 1'b1);
      step_check("R6 hold cnt_en low");
      drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b0);
      step_check("R6 hold carry_en low");

      // R5 wrap and R7 carry independent of cnt_en
      drive(1'b1, 1'b0, 4'd15, 1'b0, 1'b0);
      step_check("R3 load 15");
      chk(tc_out == 1'b0, "R7 tc low when carry_en low", tc_out, 0);
      carry_en = 1'b1; #1;
      chk(tc_out == 1'b1, "R7 tc follows carry_en, cnt_en low", tc_out, 1);
      pload_n = 1'b1; cnt_en = 1'b1;
      step_check("R5 wrap to zero");
      chk(cnt_q == 4'd0, "R5 wrap value", cnt_q, 0);

      // R1 no change between edges
      drive(1'b0, 1'b0, 4'd11, 1'b1, 1'b1);
      #2;
      chk(cnt_q == exp_q, "R1 no change before edge", cnt_q, exp_q);
      drive(1'b1, 1'b0, 4'd11, 1'b0, 1'b0);
      #1;
      chk(cnt_q == exp_q, "R1 still unchanged", cnt_q, exp_q);
      step_check("R1 load at edge");

      // random phase against model
      for (int k = 0; k < 400; k++) begin
         drive(($urandom % 8) != 0, ($urandom % 6) != 0, 4'($urandom),
               ($urandom % 4) != 0, ($urandom % 4) != 0);
         step_check("R4 random");
      end

      // R8 chain
      ch_clr_n = 1'b0; ch_en = 1'b1;
      edge_wait();
      ch_clr_n = 1'b1;
      for (int k = 1; k <= 256; k++) begin
         edge_wait();
         chk({hi_q, lo_q} == 8'(k), "R8 chain count", {hi_q, lo_q}, k % 256);
      end
      ch_en = 1'b0;
      edge_wait();
      chk({hi_q, lo_q} == 8'd0, "R8 chain hold after wrap", {hi_q, lo_q}, 0);

      // R9 modulus ten
      md_init_n = 1'b0; md_en = 1'b1;
      edge_wait();
      md_init_n = 1'b1;
      for (int k = 1; k <= 25; k++) begin
         edge_wait();
         chk(md_q == 4'(k % 10), "R9 mod ten", md_q, k % 10);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule